// File: doc/BRIEF.md
# ASID-Tagged Fully Associative Translation Buffer

This block is a small fully associative translation buffer for 64-bit virtual addresses with 4 KB pages. A lookup is combinational: the address's region bits (63:62) and page number (bits 43:12) are compared against every entry in the same cycle. The result is a hit flag, a physical address built from the entry's frame number and the page offset, and an address-error flag. The error flag is raised when bits 61:44 are not a uniform fill of the level the region requires.

Each entry is stamped with the address space identifier that is current when the entry is written, and may carry a global flag. The identifier is not compared during lookups. The comparison runs once for every entry when a new current identifier is written, and the one-bit outcome is kept per entry as an enable. Lookups then need only that bit.

Entries are written by software, either at a chosen index or at a pseudo-random index that never falls below a programmable wired boundary. Before a new entry is stored, every other entry that it would duplicate is invalidated, and this includes wired entries. If two or more entries are purged this way, a sticky multi-match flag is set.

Top module: `asid_tlb`

## Requirements
- R1: An entry hits when it is valid, its enable bit is set, its region equals vaddr[63:62] and its page number equals vaddr[43:12]. On a hit, lk_paddr = {frame, vaddr[11:0]} in the same cycle. On a miss, lk_hit is 0 and lk_paddr is 0.
- R2: Bits 61:44 must all equal bit 63 (all zeros for regions 00 and 01, all ones for regions 10 and 11). Otherwise lk_addr_err is 1 and lk_hit is 0.
- R3: A written entry takes the current identifier as its tag. It can translate only while its tag equals the current identifier, or when its global bit is set.
- R4: Writing a new current identifier re-evaluates every entry's enable bit from the next cycle on. A written entry is enabled from the cycle after its write.
- R5: A write of a valid entry first invalidates every other valid entry that has the same region and page number and the same tag, or where either entry is global. Wired entries are included.
- R6: The multi-match flag is set when a single write purges two or more entries. Once set, it stays set until reset.
- R7: An indexed write (wr_random=0) stores at wr_index. A random write (wr_random=1) stores at an index in the range wired to N-1, so entries below wired are never replaced by it.
- R8: After reset all entries are invalid, the multi-match flag is 0 and the current identifier is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_vaddr | input | 64 | Lookup virtual address |
| lk_hit | output | 1 | Translation found |
| lk_addr_err | output | 1 | Bits 61:44 not a uniform fill for the region |
| lk_paddr | output | 40 | Frame number and page offset |
| asid_we | input | 1 | Write a new current identifier |
| asid_in | input | 8 | New current identifier |
| wr_en | input | 1 | Write an entry |
| wr_random | input | 1 | 1: random index, 0: wr_index |
| wr_index | input | 4 | Index for indexed writes |
| wr_region | input | 2 | Region of the new entry |
| wr_vpn | input | 32 | Page number of the new entry |
| wr_global | input | 1 | Global flag of the new entry |
| wr_valid | input | 1 | Valid flag of the new entry |
| wr_pfn | input | 28 | Frame number of the new entry |
| wired | input | 4 | Lowest index open to random writes |
| multi_hit_flag | output | 1 | Sticky flag for a multi-entry purge |

## Verification
The assertions assume that every input is driven to a known value once reset is released. The enable check also assumes that a write and an identifier change do not happen in the same cycle. The one-hot hit check relies on the block's own purge, not on the stimulus, to keep entries from duplicating one another. The bench changes all inputs at the falling edge and never issues an identifier write together with an entry write. It builds its duplicate cases deliberately: once with a single conflicting entry and once with two entries under different identifiers.

// File: rtl/asid_tlb.sv
module asid_tlb #(
  parameter int N      = 16,
  parameter int ASID_W = 8,
  parameter int VPN_W  = 32,
  parameter int PFN_W  = 28,
  localparam int IDX_W = $clog2(N),
  localparam int PA_W  = PFN_W + 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [63:0]       lk_vaddr,
  output logic              lk_hit,
  output logic              lk_addr_err,
  output logic [PA_W-1:0]   lk_paddr,
  input  logic              asid_we,
  input  logic [ASID_W-1:0] asid_in,
  input  logic              wr_en,
  input  logic              wr_random,
  input  logic [IDX_W-1:0]  wr_index,
  input  logic [1:0]        wr_region,
  input  logic [VPN_W-1:0]  wr_vpn,
  input  logic              wr_global,
  input  logic              wr_valid,
  input  logic [PFN_W-1:0]  wr_pfn,
  input  logic [IDX_W-1:0]  wired,
  output logic              multi_hit_flag
);
  localparam logic [IDX_W-1:0] TOP = IDX_W'(N - 1);

  logic [N-1:0]       v, g, en, hit_vec, cf_vec;
  logic [1:0]         e_rg   [N];
  logic [VPN_W-1:0]   e_vpn  [N];
  logic [ASID_W-1:0]  e_asid [N];
  logic [PFN_W-1:0]   e_pfn  [N];
  logic [ASID_W-1:0]  cur_asid;
  logic [IDX_W-1:0]   rnd, rnd_sel, tgt;
  logic [IDX_W:0]     cf_cnt;
  logic [PFN_W-1:0]   sel_pfn;

  assign lk_addr_err = lk_vaddr[61:44] != {18{lk_vaddr[63]}};

  assign rnd_sel = (rnd < wired) ? TOP : rnd;
  assign tgt     = wr_random ? rnd_sel : wr_index;

  for (genvar i = 0; i < N; i++) begin : g_ent
    assign hit_vec[i] = v[i] & en[i] & (e_rg[i] == lk_vaddr[63:62]) &
                        (e_vpn[i] == lk_vaddr[12+VPN_W-1:12]);
    assign cf_vec[i]  = wr_valid & v[i] & (tgt != IDX_W'(i)) &
                        (e_rg[i] == wr_region) & (e_vpn[i] == wr_vpn) &
                        (g[i] | wr_global | (e_asid[i] == cur_asid));
  end

  always_comb begin
    sel_pfn = '0;
    cf_cnt  = '0;
    for (int i = 0; i < N; i++) begin
      if (hit_vec[i]) sel_pfn = sel_pfn | e_pfn[i];
      if (cf_vec[i])  cf_cnt  = cf_cnt + 1'b1;
    end
  end

  assign lk_hit   = (|hit_vec) & ~lk_addr_err;
  assign lk_paddr = lk_hit ? {sel_pfn, lk_vaddr[11:0]} : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v              <= '0;
      en             <= '0;
      cur_asid       <= '0;
      multi_hit_flag <= 1'b0;
      rnd            <= TOP;
    end else begin
      rnd <= (rnd_sel <= wired) ? TOP : rnd_sel - 1'b1;
      if (asid_we) begin
        cur_asid <= asid_in;
        for (int i = 0; i < N; i++) en[i] <= g[i] | (e_asid[i] == asid_in);
      end
      if (wr_en) begin
        v       <= v & ~cf_vec;
        v[tgt]  <= wr_valid;
        en[tgt] <= wr_global | ~asid_we | (cur_asid == asid_in);
        if (cf_cnt > 1) multi_hit_flag <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      g[tgt]      <= wr_global;
      e_rg[tgt]   <= wr_region;
      e_vpn[tgt]  <= wr_vpn;
      e_asid[tgt] <= cur_asid;
      e_pfn[tgt]  <= wr_pfn;
    end
  end

  // R1
  hit_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  // R2
  err_blocks_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_addr_err |-> !lk_hit);

  // R4
  wr_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_valid && !asid_we) |=> en[$past(tgt)]);

  // R5
  purge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((v & $past(cf_vec)) == '0));

  // R6
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    multi_hit_flag |=> multi_hit_flag);

  // R7
  rnd_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_random) |-> (tgt >= wired));
endmodule

// File: tb/asid_tlb_tb.sv
module asid_tlb_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [63:0] lk_vaddr = '0;
  logic lk_hit, lk_addr_err, multi_hit_flag;
  logic [39:0] lk_paddr;
  logic asid_we = 0, wr_en = 0, wr_random = 0, wr_global = 0, wr_valid = 0;
  logic [7:0] asid_in = '0;
  logic [3:0] wr_index = '0, wired = '0;
  logic [1:0] wr_region = '0;
  logic [31:0] wr_vpn = '0;
  logic [27:0] wr_pfn = '0;
  int errors = 0, checks = 0;

  always #4 clk = ~clk;

  asid_tlb dut_i (.*);

  // {vaddr, hit, err, paddr}
  localparam logic [105:0] VEC [8] = '{
    {64'h0000000001000123, 1'b1, 1'b0, 40'h0AAAAAA123},
    {64'hFFFFF00002000FFF, 1'b1, 1'b0, 40'h0BBBBBBFFF},
    {64'h4000000001000000, 1'b1, 1'b0, 40'h0CCCCCC000},
    {64'hBFFFF00001000000, 1'b0, 1'b0, 40'h0},
    {64'h0000000001001000, 1'b0, 1'b0, 40'h0},
    {64'h0000100001000123, 1'b0, 1'b1, 40'h0},
    {64'hC000000002000000, 1'b0, 1'b1, 40'h0},
    {64'h3FFFF00001000000, 1'b0, 1'b1, 40'h0}
  };
  localparam logic [63:0] VA_U = 64'h0000000001000123;
  localparam logic [63:0] VA_K = 64'hFFFFF00002000FFF;
  localparam logic [63:0] VA_S = 64'h4000000001000000;

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic look(input logic [63:0] va, input logic h, input logic [39:0] pa, input string req);
    @(negedge clk);
    lk_vaddr = va;
    #1;
    chk(lk_hit === h && lk_paddr === pa, req, {23'b0, lk_hit, lk_paddr}, {23'b0, h, pa});
  endtask

  task automatic set_asid(input logic [7:0] a);
    @(negedge clk); asid_we = 1; asid_in = a;
    @(negedge clk); asid_we = 0;
  endtask

  task automatic wr(input logic rnd, input logic [3:0] idx, input logic [1:0] rg,
                    input logic [31:0] vpn, input logic gl, input logic [27:0] pfn);
    @(negedge clk);
    wr_en = 1; wr_random = rnd; wr_index = idx; wr_region = rg;
    wr_vpn = vpn; wr_global = gl; wr_valid = 1; wr_pfn = pfn;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic flag_is(input logic e, input string req);
    @(negedge clk);
    chk(multi_hit_flag === e, req, {63'b0, multi_hit_flag}, {63'b0, e});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R8 reset state
    look(VA_U, 1'b0, 40'h0, "R8 empty after reset");
    flag_is(1'b0, "R8 flag clear");

    set_asid(8'h11);
    wr(0, 4'd0, 2'b00, 32'h1000, 0, 28'h0AAAAAA);
    wr(0, 4'd1, 2'b11, 32'h2000, 1, 28'h0BBBBBB);
    wr(0, 4'd2, 2'b01, 32'h1000, 0, 28'h0CCCCCC);
    // R1 R2 table
    foreach (VEC[k]) begin
      @(negedge clk);
      lk_vaddr = VEC[k][105:42];
      #1;
      chk(lk_hit === VEC[k][41] && lk_addr_err === VEC[k][40] && lk_paddr === VEC[k][39:0],
          (VEC[k][40] ? "R2 vector" : "R1 vector"),
          {22'b0, lk_hit, lk_addr_err, lk_paddr}, {22'b0, VEC[k][41:0]});
    end

    // R3 R4 context switch
    set_asid(8'h22);
    look(VA_U, 1'b0, 40'h0, "R3 other tag misses");
    look(VA_K, 1'b1, 40'h0BBBBBBFFF, "R3 global hits");
    look(VA_S, 1'b0, 40'h0, "R4 enable re-evaluated");
    wr(0, 4'd3, 2'b00, 32'h1000, 0, 28'h0DDDDDD);
    look(VA_U, 1'b1, 40'h0DDDDDD123, "R3 entry tagged with current id");
    set_asid(8'h11);
    look(VA_U, 1'b1, 40'h0AAAAAA123, "R4 switch back");
    flag_is(1'b0, "R5 different tags do not conflict");

    // R7 random writes above wired
    @(negedge clk); wired = 4'd4;
    for (int k = 0; k < 20; k++) wr(1, 4'd0, 2'b00, 32'h5000 + k, 0, 28'(k));
    look(VA_U, 1'b1, 40'h0AAAAAA123, "R7 wired entry 0 kept");
    look(VA_K, 1'b1, 40'h0BBBBBBFFF, "R7 wired entry 1 kept");
    look(64'h0000000005013ABC, 1'b1, {28'h13, 12'hABC}, "R7 random entry stored");

    // R5 single conflict purges a wired entry
    wr(0, 4'd10, 2'b00, 32'h1000, 0, 28'h0EEEEEE);
    look(VA_U, 1'b1, 40'h0EEEEEE123, "R5 wired duplicate purged");
    flag_is(1'b0, "R6 single purge leaves flag");
    set_asid(8'h22);
    look(VA_U, 1'b1, 40'h0DDDDDD123, "R5 other tag kept");
    set_asid(8'h11);

    // R6 global write purges two entries
    wr(0, 4'd12, 2'b00, 32'h1000, 1, 28'h0F0F0F0);
    flag_is(1'b1, "R6 flag set");
    look(VA_U, 1'b1, 40'h0F0F0F0123, "R5 global replaces both");
    set_asid(8'h22);
    look(VA_U, 1'b1, 40'h0F0F0F0123, "R5 tag-22 copy purged");
    wr(0, 4'd13, 2'b01, 32'h7777, 0, 28'h1);
    flag_is(1'b1, "R6 flag sticky");

    // R8 reset again
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    flag_is(1'b0, "R8 flag cleared");
    look(VA_K, 1'b0, 40'h0, "R8 entries invalid");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule